// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts activity for performance analysis. It holds one 64-bit cycle counter and six 32-bit event counters, each event counter driven by its own event input line. Software configures the unit through a small register bus: a control register with a global enable, two self-clearing write-one pulses that zero the counters, a divide-by-64 prescale for the cycle counter, a choice of the cycle counter's overflow point, an event-export enable and a switch that stops the cycle counter while counting is prohibited.

Every counter wrap is recorded in an overflow status register. Software clears it by writing ones. An interrupt is raised whenever a recorded overflow has its interrupt-enable bit set. A privilege-level input and a partition index split the event counters into two groups: counters at or above the index belong to the higher level. Lower-level software can neither gate those counters with the global enable nor zero them with the reset pulse.

Register map (word addresses): 0 control, 1 overflow status (write 1 to clear), 2 counter enable, 3 interrupt enable, 4 cycle count bits [31:0], 5 cycle count bits [63:32], 16+n event counter n. In the three flag registers, bit n is event counter n and bit 31 is the cycle counter. All counter addresses can be written. Read data appears one clock after `rd_addr` is presented and shows the state before that edge's update.

Top module: `pmu_unit`

## Requirements
- R1: After reset the control register reads 0x0000_3000 (identity bits [31:16] zero, event counter count 6 in bits [15:11], every other bit 0), all counters and flag registers are 0, and `irq` and `exp_out` are 0.
- R2: The control register bits are: 0 global enable, 1 event-counter reset pulse, 2 cycle-counter reset pulse, 3 divide-by-64, 4 export enable, 5 stop-when-prohibited, 6 long overflow select. Bits [10:7], 2 and 1 always read as 0, and bits [15:11] cannot be written.
- R3: Event counter n increments on a clock where `evt_in[n]` is high, counter-enable bit n is set and the global enable applies to it. Its wrap from all ones to zero sets overflow bit n.
- R4: The cycle counter advances every clock while the global enable and counter-enable bit 31 are set. When bit 5 is 1 and `cnt_prohibit` is high, it holds. When bit 5 is 0, `cnt_prohibit` has no effect.
- R5: With bit 3 set, the enabled cycle counter advances exactly once per 64 enabled clocks, using a 6-bit prescaler that runs only while the counter is enabled.
- R6: With bit 6 at 0, an increment that takes cycle bit 31 from 1 to 0 sets overflow bit 31. With bit 6 at 1, only an increment that takes cycle bit 63 from 1 to 0 does.
- R7: Writing 1 to bit 2 zeroes the cycle counter and its prescaler and leaves overflow bit 31 unchanged.
- R8: Writing 1 to bit 1 zeroes event counters but not the cycle counter, and changes no overflow bit. With `priv_high` low, counters with index at or above `part_idx` keep their value. With `priv_high` high, all event counters are zeroed.
- R9: With `priv_high` low, counters at or above `part_idx` count while the global enable is 0. With `priv_high` high, the global enable gates every event counter.
- R10: `irq` is high one clock after any overflow bit is set together with its interrupt-enable bit.
- R11: Writing 1 to an overflow status bit clears it. An overflow set in the same clock wins.
- R12: `exp_out` is `evt_in` registered by one clock while bit 4 is set, and 0 otherwise. Bit 4 has no effect on `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 32 | Registered read data |
| evt_in | input | 6 | One event line per event counter |
| priv_high | input | 1 | 1 when the higher privilege level is active |
| part_idx | input | 3 | First event counter reserved for the higher level |
| cnt_prohibit | input | 1 | Counting is prohibited |
| exp_out | output | 6 | Exported events |
| irq | output | 1 | Overflow interrupt |

## Verification
The counters are driven by single event pulses, by held event lines and by preloaded values one step short of a wrap. These patterns separate plain counting from overflow recording. The cycle counter is sampled twice a known number of clocks apart under each mode: plain, prescaled, prohibited with and without the stop switch. The distance between the two samples shows which mode is in effect. The partition is tested with a split index at both privilege levels. This shows whether the enable and the reset pulse honour the reserved group. A behavioural model is compared with the read data, the interrupt and the export bus on every clock, so a wrong timing or priority shows up wherever it occurs.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] A_CTRL  = 5'd0;
  localparam logic [ADDR_W-1:0] A_OVS   = 5'd1;
  localparam logic [ADDR_W-1:0] A_CEN   = 5'd2;
  localparam logic [ADDR_W-1:0] A_IEN   = 5'd3;
  localparam logic [ADDR_W-1:0] A_CYCLO = 5'd4;
  localparam logic [ADDR_W-1:0] A_CYCHI = 5'd5;
  localparam logic [ADDR_W-1:0] A_EVT0  = 5'd16;

  // control bit positions
  localparam int B_EN    = 0;
  localparam int B_EVRST = 1;
  localparam int B_CYRST = 2;
  localparam int B_DIV   = 3;
  localparam int B_EXP   = 4;
  localparam int B_DP    = 5;
  localparam int B_LC    = 6;

  // flag bit of the cycle counter in status / enable registers
  localparam int CYC_FLAG = 31;

  typedef struct packed {
    logic lc;
    logic dp;
    logic xp;
    logic div;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 6,
  parameter logic [15:0] ID_CODE = 16'h0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [6:0]        wr_bits,
  output ctrl_t             cfg,
  output logic              clr_cyc,
  output logic              clr_evt,
  output logic [31:0]       rd_word
);
  logic hit;
  assign hit = wr_en && (wr_addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (hit) begin
      cfg.en  <= wr_bits[B_EN];
      cfg.div <= wr_bits[B_DIV];
      cfg.xp  <= wr_bits[B_EXP];
      cfg.dp  <= wr_bits[B_DP];
      cfg.lc  <= wr_bits[B_LC];
    end
  end

  // self-clearing pulses, never stored
  assign clr_cyc = hit && wr_bits[B_CYRST];
  assign clr_evt = hit && wr_bits[B_EVRST];

  assign rd_word = {ID_CODE, 5'(NUM_EVT), 4'b0000,
                    cfg.lc, cfg.dp, cfg.xp, cfg.div, 2'b00, cfg.en};
endmodule

// File: rtl/pmu_cyc.sv
module pmu_cyc
  import pmu_pkg::*;
#(
  parameter int CYC_W   = 64,
  parameter int PRESC_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             div,
  input  logic             lc,
  input  logic             clr,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [31:0]      wdata,
  output logic [CYC_W-1:0] cnt,
  output logic             ovf
);
  localparam int HI_W = CYC_W - 32;

  logic [PRESC_W-1:0] presc;
  logic [CYC_W-1:0]   nxt;
  logic               tick;
  logic               fall;

  assign tick = run && (!div || (&presc));
  assign nxt  = cnt + 1'b1;
  assign fall = lc ? (cnt[CYC_W-1] && !nxt[CYC_W-1]) : (cnt[31] && !nxt[31]);
  assign ovf  = tick && !clr && !wr_lo && !wr_hi && fall;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt   <= '0;
      presc <= '0;
    end else begin
      if (run) presc <= presc + 1'b1;
      if (wr_lo)      cnt[31:0]       <= wdata;
      else if (wr_hi) cnt[CYC_W-1:32] <= wdata[HI_W-1:0];
      else if (tick)  cnt             <= nxt;
    end
  end
endmodule

// File: rtl/pmu_evt.sv
module pmu_evt #(
  parameter int EVT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  input  logic             wr,
  input  logic [EVT_W-1:0] wdata,
  output logic [EVT_W-1:0] cnt,
  output logic             wrap
);
  assign wrap = inc && !clr && !wr && (&cnt);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (wr)     cnt <= wdata;
    else if (inc)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pmu_unit.sv
module pmu_unit
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 6,
  parameter int EVT_W   = 32,
  parameter int CYC_W   = 64,
  parameter int PRESC_W = 6,
  parameter logic [15:0] ID_CODE = 16'h0000,
  localparam int PW = $clog2(NUM_EVT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [31:0]        wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [31:0]        rd_data,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               priv_high,
  input  logic [PW-1:0]      part_idx,
  input  logic               cnt_prohibit,
  output logic [NUM_EVT-1:0] exp_out,
  output logic               irq
);
  localparam logic [31:0] FLAG_MASK = 32'h8000_0000 | 32'((1 << NUM_EVT) - 1);

  ctrl_t            cfg;
  logic             clr_cyc, clr_evt;
  logic [31:0]      ctrl_word;
  logic [CYC_W-1:0] cyc_cnt;
  logic             cyc_ovf, cyc_run;
  logic [EVT_W-1:0] evt_cnt [NUM_EVT];
  logic [NUM_EVT-1:0] evt_wrap;
  logic [31:0]      ovs_q, cen_q, ien_q, set_vec, w1c, rd_nxt;

  pmu_ctrl #(.NUM_EVT(NUM_EVT), .ID_CODE(ID_CODE)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_bits(wr_data[6:0]), .cfg(cfg), .clr_cyc(clr_cyc),
    .clr_evt(clr_evt), .rd_word(ctrl_word)
  );

  assign cyc_run = cfg.en && cen_q[CYC_FLAG] && !(cfg.dp && cnt_prohibit);

  pmu_cyc #(.CYC_W(CYC_W), .PRESC_W(PRESC_W)) u_cyc (
    .clk(clk), .rst(rst), .run(cyc_run), .div(cfg.div), .lc(cfg.lc),
    .clr(clr_cyc),
    .wr_lo(wr_en && (wr_addr == A_CYCLO)),
    .wr_hi(wr_en && (wr_addr == A_CYCHI)),
    .wdata(wr_data), .cnt(cyc_cnt), .ovf(cyc_ovf)
  );

  for (genvar n = 0; n < NUM_EVT; n++) begin : g_evt
    logic reserved, gate;
    assign reserved = (n >= int'(part_idx));
    assign gate     = cfg.en || (!priv_high && reserved);
    pmu_evt #(.EVT_W(EVT_W)) u_evt (
      .clk(clk), .rst(rst),
      .inc(evt_in[n] && gate && cen_q[n]),
      .clr(clr_evt && (priv_high || !reserved)),
      .wr(wr_en && (wr_addr == ADDR_W'(int'(A_EVT0) + n))),
      .wdata(wr_data[EVT_W-1:0]),
      .cnt(evt_cnt[n]), .wrap(evt_wrap[n])
    );
  end

  always_comb begin
    set_vec = '0;
    set_vec[CYC_FLAG] = cyc_ovf;
    set_vec[NUM_EVT-1:0] = evt_wrap;
    w1c = (wr_en && (wr_addr == A_OVS)) ? (wr_data & FLAG_MASK) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovs_q <= '0;
      cen_q <= '0;
      ien_q <= '0;
    end else begin
      ovs_q <= (ovs_q & ~w1c) | set_vec;
      if (wr_en && (wr_addr == A_CEN)) cen_q <= wr_data & FLAG_MASK;
      if (wr_en && (wr_addr == A_IEN)) ien_q <= wr_data & FLAG_MASK;
    end
  end

  always_comb begin
    rd_nxt = '0;
    case (rd_addr)
      A_CTRL:  rd_nxt = ctrl_word;
      A_OVS:   rd_nxt = ovs_q;
      A_CEN:   rd_nxt = cen_q;
      A_IEN:   rd_nxt = ien_q;
      A_CYCLO: rd_nxt = cyc_cnt[31:0];
      A_CYCHI: rd_nxt = 32'(cyc_cnt[CYC_W-1:32]);
      default: begin
        for (int n = 0; n < NUM_EVT; n++)
          if (rd_addr == ADDR_W'(int'(A_EVT0) + n)) rd_nxt = 32'(evt_cnt[n]);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
      exp_out <= '0;
    end else begin
      rd_data <= rd_nxt;
      irq     <= |(ovs_q & ien_q);
      exp_out <= cfg.xp ? evt_in : '0;
    end
  end
endmodule

// File: rtl/pmu_unit_chk.sv
module pmu_unit_chk
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 6,
  parameter int CYC_W   = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               irq,
  input logic [31:0]        ovs_q,
  input logic [31:0]        ien_q,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic [31:0]        rd_data,
  input logic               clr_cyc,
  input logic               clr_evt,
  input logic [CYC_W-1:0]   cyc_cnt,
  input logic [NUM_EVT-1:0] exp_out,
  input logic               xp
);
  // R10: interrupt follows enabled overflow flags one clock later
  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == |($past(ovs_q & ien_q))));

  // R2: reserved and pulse bits read as zero
  assert_ctrl_zero_bits_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_addr) == A_CTRL && !$past(rst)) |-> (rd_data[10:7] == 4'b0 && rd_data[2:1] == 2'b0));

  // R7: cycle reset pulse zeroes the counter
  assert_cyc_clear_R7: assert property (@(posedge clk) disable iff (rst)
    clr_cyc |=> (cyc_cnt == '0));

  // R7: cycle reset pulse keeps the cycle overflow flag
  assert_cyc_clear_keeps_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_cyc && ovs_q[CYC_FLAG]) |=> ovs_q[CYC_FLAG]);

  // R8: event reset pulse clears no overflow flag
  assert_evt_clear_keeps_flags_R8: assert property (@(posedge clk) disable iff (rst)
    clr_evt |=> ((ovs_q[NUM_EVT-1:0] & $past(ovs_q[NUM_EVT-1:0])) == $past(ovs_q[NUM_EVT-1:0])));

  // R12: export bus silent while export is off
  assert_export_off_R12: assert property (@(posedge clk) disable iff (rst)
    !xp |=> (exp_out == '0));
endmodule

bind pmu_unit pmu_unit_chk #(.NUM_EVT(NUM_EVT), .CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .ovs_q(ovs_q), .ien_q(ien_q),
  .rd_addr(rd_addr), .rd_data(rd_data), .clr_cyc(clr_cyc),
  .clr_evt(clr_evt), .cyc_cnt(cyc_cnt), .exp_out(exp_out), .xp(cfg.xp)
);

// File: tb/sim_pmu_unit.sv
`timescale 1ns/1ps
module sim_pmu_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [5:0]  evt_in = '0;
  logic        priv_high = 1'b1;
  logic [2:0]  part_idx = 3'd6;
  logic        cnt_prohibit = 1'b0;
  logic [5:0]  exp_out;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pmu_unit u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .evt_in(evt_in), .priv_high(priv_high),
    .part_idx(part_idx), .cnt_prohibit(cnt_prohibit), .exp_out(exp_out), .irq(irq)
  );

  // ---------------- behavioural reference ----------------
  logic [63:0] m_cyc;
  logic [31:0] m_evt [6];
  logic [31:0] m_ovs, m_cen, m_ien;
  bit m_en, m_div, m_xp, m_dp, m_lc;
  int m_presc;
  logic [31:0] e_rd;
  logic        e_irq;
  logic [5:0]  e_exp;
  bit model_live = 0;

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a)
      5'd0: return {16'h0, 5'd6, 4'b0, m_lc, m_dp, m_xp, m_div, 2'b00, m_en};
      5'd1: return m_ovs;
      5'd2: return m_cen;
      5'd3: return m_ien;
      5'd4: return m_cyc[31:0];
      5'd5: return m_cyc[63:32];
      default: if (a >= 16 && a < 22) return m_evt[a-16]; else return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    case (a)
      5'd0: return "R2";
      5'd1: return "R11";
      5'd4, 5'd5: return "R4 R5 R6 R7";
      default: return "R3 R8 R9";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cyc = '0; m_ovs = '0; m_cen = '0; m_ien = '0;
      foreach (m_evt[i]) m_evt[i] = '0;
      {m_en, m_div, m_xp, m_dp, m_lc} = '0;
      m_presc = 0; e_rd = '0; e_irq = 1'b0; e_exp = '0;
      model_live = 0;
    end else begin
      logic [31:0] setv, clrv;
      logic [63:0] old;
      bit run, tick, wctl;
      e_rd  = m_read(rd_addr);
      e_irq = |(m_ovs & m_ien);
      e_exp = m_xp ? evt_in : 6'h0;
      setv = '0;
      wctl = wr_en && wr_addr == 5'd0;
      run = m_en && m_cen[31] && !(m_dp && cnt_prohibit);
      if (wctl && wr_data[2]) begin
        m_cyc = '0; m_presc = 0;
      end else begin
        tick = run && (!m_div || m_presc == 63);
        if (run) m_presc = (m_presc + 1) % 64;
        if (wr_en && wr_addr == 5'd4) m_cyc[31:0] = wr_data;
        else if (wr_en && wr_addr == 5'd5) m_cyc[63:32] = wr_data;
        else if (tick) begin
          old = m_cyc;
          m_cyc = m_cyc + 1;
          if (m_lc ? (old[63] && !m_cyc[63]) : (old[31] && !m_cyc[31])) setv[31] = 1'b1;
        end
      end
      for (int n = 0; n < 6; n++) begin
        bit res, inc;
        res = n >= int'(part_idx);
        inc = evt_in[n] && (m_en || (!priv_high && res)) && m_cen[n];
        if (wctl && wr_data[1] && (priv_high || !res)) m_evt[n] = '0;
        else if (wr_en && wr_addr == 5'(16 + n)) m_evt[n] = wr_data;
        else if (inc) begin
          if (m_evt[n] == 32'hFFFF_FFFF) setv[n] = 1'b1;
          m_evt[n] = m_evt[n] + 1;
        end
      end
      clrv = (wr_en && wr_addr == 5'd1) ? (wr_data & 32'h8000_003F) : '0;
      m_ovs = (m_ovs & ~clrv) | setv;
      if (wr_en && wr_addr == 5'd2) m_cen = wr_data & 32'h8000_003F;
      if (wr_en && wr_addr == 5'd3) m_ien = wr_data & 32'h8000_003F;
      if (wctl) begin
        m_en = wr_data[0]; m_div = wr_data[3]; m_xp = wr_data[4];
        m_dp = wr_data[5]; m_lc = wr_data[6];
      end
      model_live = 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the reference
  always @(negedge clk) begin
    if (!rst && model_live && !done) begin
      chk(tag_of(rd_addr), rd_data, e_rd);
      chk("R10 irq", {31'b0, irq}, {31'b0, e_irq});
      chk("R12 export", {26'b0, exp_out}, {26'b0, e_exp});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rdv(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); v = rd_data;
  endtask

  task automatic pulse(input logic [5:0] m);
    @(negedge clk); evt_in = m;
    @(negedge clk); evt_in = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, a, b;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    rdv(5'd0, v); chk("R1 ctrl", v, 32'h0000_3000);
    rdv(5'd4, v); chk("R1 cyc", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2: all writable bits set, pulses and reserved read zero
    wr(5'd0, 32'hFFFF_FFFF);
    rdv(5'd0, v); chk("R2 ctrl readback", v, 32'h0000_3079);
    wr(5'd0, 32'h0);

    // R9: lower level, partition 4, global enable off
    priv_high = 1'b0; part_idx = 3'd4;
    wr(5'd2, 32'h8000_003F);
    repeat (3) pulse(6'h3F);
    rdv(5'd20, v); chk("R9 reserved counts", v, 32'd3);
    rdv(5'd16, v); chk("R9 gated counter", v, 32'd0);

    // R3: counting with global enable
    wr(5'd0, 32'h1);
    repeat (2) pulse(6'h3F);
    rdv(5'd16, v); chk("R3 evt0", v, 32'd2);
    rdv(5'd20, v); chk("R3 evt4", v, 32'd5);

    // R8: lower-level reset spares reserved counters
    wr(5'd0, 32'h3);
    rdv(5'd16, v); chk("R8 evt0 cleared", v, 32'd0);
    rdv(5'd20, v); chk("R8 evt4 kept", v, 32'd5);
    priv_high = 1'b1;
    wr(5'd0, 32'h3);
    rdv(5'd20, v); chk("R8 evt4 cleared high", v, 32'd0);

    // R9: at higher level global enable gates all
    wr(5'd0, 32'h0);
    pulse(6'h3F);
    rdv(5'd21, v); chk("R9 high gated", v, 32'd0);
    wr(5'd0, 32'h1);

    // R3 overflow, R10, R11
    wr(5'd17, 32'hFFFF_FFFF);
    pulse(6'h02);
    rdv(5'd17, v); chk("R3 wrap value", v, 32'd0);
    rdv(5'd1, v);  chk("R3 overflow flag", v & 32'h3F, 32'h2);
    chk("R10 irq masked", {31'b0, irq}, 32'h0);
    wr(5'd3, 32'h2);
    @(negedge clk);
    chk("R10 irq raised", {31'b0, irq}, 32'h1);
    wr(5'd0, 32'h3);  // R8 reset pulse leaves flag
    rdv(5'd1, v); chk("R8 flag kept", v & 32'h3F, 32'h2);
    wr(5'd1, 32'h2);
    rdv(5'd1, v); chk("R11 flag cleared", v & 32'h3F, 32'h0);
    chk("R10 irq dropped", {31'b0, irq}, 32'h0);

    // R4: cycle counter rate
    wr(5'd0, 32'h5);
    rdv(5'd4, a); repeat (10) @(negedge clk); b = rd_data;
    chk("R4 every clock", b - a, 32'd10);
    cnt_prohibit = 1'b1;
    rdv(5'd4, a); repeat (10) @(negedge clk); b = rd_data;
    chk("R4 prohibit ignored", b - a, 32'd10);
    wr(5'd0, 32'h21);
    rdv(5'd4, a); repeat (10) @(negedge clk); b = rd_data;
    chk("R4 stopped", b - a, 32'd0);
    cnt_prohibit = 1'b0;

    // R5: prescale by 64
    wr(5'd0, 32'h9);
    rdv(5'd4, a); repeat (128) @(negedge clk); b = rd_data;
    chk("R5 divide", b - a, 32'd2);

    // R6: short overflow point
    wr(5'd0, 32'h1);
    wr(5'd5, 32'h0); wr(5'd4, 32'hFFFF_FFF0);
    repeat (30) @(negedge clk);
    rdv(5'd1, v); chk("R6 short ovf", v & 32'h8000_0000, 32'h8000_0000);
    rdv(5'd5, v); chk("R6 carry to hi", v, 32'h1);
    // R7: clear keeps flag
    wr(5'd0, 32'h5);
    rdv(5'd4, v); chk("R7 cleared", {31'b0, v < 32'd4}, 32'h1);
    rdv(5'd1, v); chk("R7 flag kept", v & 32'h8000_0000, 32'h8000_0000);
    wr(5'd1, 32'h8000_0000);
    // R6: long overflow point
    wr(5'd0, 32'h41);
    wr(5'd5, 32'h0); wr(5'd4, 32'hFFFF_FFF0);
    repeat (30) @(negedge clk);
    rdv(5'd1, v); chk("R6 no ovf at bit31", v & 32'h8000_0000, 32'h0);
    wr(5'd5, 32'hFFFF_FFFF); wr(5'd4, 32'hFFFF_FFF0);
    repeat (30) @(negedge clk);
    rdv(5'd1, v); chk("R6 long ovf", v & 32'h8000_0000, 32'h8000_0000);
    rdv(5'd5, v); chk("R6 hi wrapped", v, 32'h0);

    // R12: export
    wr(5'd0, 32'h11);
    @(negedge clk); evt_in = 6'h2A;
    @(negedge clk); chk("R12 export on", {26'b0, exp_out}, 32'h2A);
    wr(5'd0, 32'h01);
    @(negedge clk); chk("R12 export off", {26'b0, exp_out}, 32'h0);
    evt_in = '0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule